// File: doc/BRIEF.md
# Coprocessor Load Transfer Sequencer

This block carries out a load-to-coprocessor instruction once decode and condition evaluation are finished. A one-cycle `start` pulse hands it a base register value, an 8-bit immediate and three flags: index, add and writeback. The block first asks the target coprocessor whether it takes the instruction. If the coprocessor refuses, the block raises an undefined-instruction exception and makes no memory access. If the coprocessor accepts, the block forms an offset address and a first transfer address. It then fetches 32-bit words from memory one at a time and passes each word to the coprocessor. The loop stops when the coprocessor marks a word as its last.

The immediate is scaled by four, so the offset runs from 0 to 1020. It is added to the base when the add flag is set and subtracted when it is clear. The index flag picks the first transfer address: the offset address when set, the plain base when clear. After each word the transfer address moves up by four. When the loop ends normally and writeback is enabled, the block presents the offset address for the base register. This is never the last incremented transfer address. A failed memory read stops the loop at once, drops the writeback and raises a data abort.

The four flag combinations used are:

- offset: index=1, writeback=0
- pre-indexed: index=1, writeback=1
- post-indexed: index=0, writeback=1
- unindexed: index=0, writeback=0, add=1

In unindexed mode the 8-bit field is an option value for the coprocessor and plays no part in any address.

The controller walks through these states:

- IDLE: waits for `start`.
- CHECK: asks the coprocessor whether it accepts the instruction.
- REQ: holds a memory read request until it is taken.
- WAIT: waits for the read response.
- DELIVER: strobes the word to the coprocessor and samples its done flag.
- FINISH: normal end.
- ABORT: memory error end.
- UNDEF: coprocessor refusal end.

The transitions are:

- IDLE→CHECK on `start`.
- CHECK→REQ when `cp_accept` is high.
- CHECK→UNDEF when `cp_accept` is low.
- REQ→WAIT when `mem_req_rdy` is high.
- WAIT→DELIVER on a good response.
- WAIT→ABORT on an error response.
- DELIVER→FINISH when `cp_done` is high.
- DELIVER→REQ when `cp_done` is low.
- FINISH, ABORT and UNDEF each return to IDLE after one cycle.

Top module: `cp_load_seq`

## Requirements
- R1: After reset, `busy`, `cp_query`, `mem_req_vld`, `cp_word_vld`, `wb_vld`, `op_done`, `undef_exc` and `dabort` are all low.
- R2: The offset address is base + 4·imm8 when the add flag is 1, and base − 4·imm8 when it is 0, computed modulo 2^32.
- R3: The first memory read address is the offset address when the index flag is 1, and the base otherwise.
- R4: Each later read address is the previous one plus 4. Each returned word appears on `cp_word` with a one-cycle `cp_word_vld` strobe, and `cp_done` is sampled in that strobe cycle. At least one word is always transferred after acceptance, and the number of words equals the strobe on which `cp_done` is high.
- R5: When the loop ends normally, `op_done` pulses for one cycle. In that same cycle `wb_vld` is high only if the writeback flag was 1, and `wb_addr` carries the offset address.
- R6: If `cp_accept` is low during the `cp_query` cycle, `undef_exc` pulses for one cycle, no memory request is issued and no writeback occurs.
- R7: A read response with `mem_rsp_err` high ends the operation. `dabort` pulses for one cycle, no further request is issued, no word is forwarded for that read, and `op_done` and `wb_vld` stay low.
- R8: In unindexed mode (index=0, writeback=0, add=1), `cp_opt_vld` is high while busy and `cp_opt` equals imm8. Reads start at the base and no writeback occurs. In all other modes `cp_opt_vld` is low.
- R9: While `mem_req_vld` is high and `mem_req_rdy` is low, the request stays asserted with an unchanged address.
- R10: `busy` rises in the cycle after `start`. It stays high up to and including the cycle of the terminating pulse (`op_done`, `undef_exc` or `dabort`). A `start` pulse while busy has no effect.
- R11: With imm8 = 0, the add flag at 0 (minus zero) and at 1 (plus zero) both give the base as offset address and writeback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled in IDLE only) |
| base_in | input | 32 | Base register value |
| imm8_in | input | 8 | Immediate / option field |
| idx_in | input | 1 | Index flag |
| add_in | input | 1 | Add flag |
| wb_in | input | 1 | Writeback flag |
| busy | output | 1 | Operation in progress |
| cp_query | output | 1 | Acceptance query to the coprocessor |
| cp_accept | input | 1 | Coprocessor accepts (valid with `cp_query`) |
| cp_opt | output | 8 | Option value for unindexed mode |
| cp_opt_vld | output | 1 | `cp_opt` is meaningful |
| mem_req_vld | output | 1 | Memory read request valid |
| mem_req_rdy | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Word read address |
| mem_rsp_vld | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read failed |
| cp_word_vld | output | 1 | Word strobe to the coprocessor |
| cp_word | output | 32 | Word delivered to the coprocessor |
| cp_done | input | 1 | Coprocessor needs no more words (valid with `cp_word_vld`) |
| wb_vld | output | 1 | Base register writeback strobe |
| wb_addr | output | 32 | Writeback value (offset address) |
| op_done | output | 1 | Normal completion pulse |
| undef_exc | output | 1 | Undefined-instruction exception pulse |
| dabort | output | 1 | Data abort pulse |

## Verification
The assertions assume that the coprocessor's `cp_accept` and `cp_done` count only in the cycles where `cp_query` and `cp_word_vld` are high. They also assume the memory sends exactly one response per accepted request, and only after that request. The bench keeps to this by driving every input from a single per-cycle task. That task answers only what the block is asking for in that cycle and returns a response exactly one cycle after each handshake, so no stray response ever reaches the WAIT state.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ,
        ST_WAIT,
        ST_DELIVER,
        ST_FINISH,
        ST_ABORT,
        ST_UNDEF
    } cpl_state_e;

    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/cpl_addr_unit.sv
module cpl_addr_unit #(
    parameter int unsigned AW   = 32,
    parameter int unsigned IMMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_op,
    input  logic [AW-1:0]   base_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            idx_i,
    input  logic            add_i,
    input  logic            ld_start,
    input  logic            step,
    output logic [AW-1:0]   off_addr,
    output logic [AW-1:0]   cur_addr,
    output logic [IMMW-1:0] imm_q
);
    import cpl_pkg::*;

    localparam logic [AW-1:0] STEP_BYTES = AW'(1 << WORD_SHIFT);

    logic [AW-1:0] base_q;
    logic          idx_q;
    logic          add_q;
    logic [AW-1:0] scaled;
    logic [AW-1:0] first_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            imm_q  <= '0;
            idx_q  <= 1'b0;
            add_q  <= 1'b0;
        end else if (ld_op) begin
            base_q <= base_i;
            imm_q  <= imm_i;
            idx_q  <= idx_i;
            add_q  <= add_i;
        end
    end

    always_comb begin
        scaled     = AW'(imm_q) << WORD_SHIFT;
        off_addr   = add_q ? (base_q + scaled) : (base_q - scaled);
        first_addr = idx_q ? off_addr : base_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (ld_start) begin
            cur_addr <= first_addr;
        end else if (step) begin
            cur_addr <= cur_addr + STEP_BYTES;
        end
    end

endmodule

// File: rtl/cpl_word_buf.sv
module cpl_word_buf #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= data_i;
        end
    end
endmodule

// File: rtl/cpl_ctrl.sv
module cpl_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic idx_i,
    input  logic add_i,
    input  logic wb_i,
    input  logic cp_accept,
    input  logic mem_req_rdy,
    input  logic mem_rsp_vld,
    input  logic mem_rsp_err,
    input  logic cp_done,
    output logic ld_op,
    output logic ld_start,
    output logic step,
    output logic capture,
    output logic busy,
    output logic cp_query,
    output logic opt_vld,
    output logic mem_req_vld,
    output logic cp_word_vld,
    output logic wb_vld,
    output logic op_done,
    output logic undef_exc,
    output logic dabort
);
    import cpl_pkg::*;

    cpl_state_e state_q, state_d;
    logic       wb_q;
    logic       opt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wb_q    <= 1'b0;
            opt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ld_op) begin
                wb_q  <= wb_i;
                opt_q <= !idx_i && !wb_i && add_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CHECK;
            ST_CHECK:   state_d = cp_accept ? ST_REQ : ST_UNDEF;
            ST_REQ:     if (mem_req_rdy) state_d = ST_WAIT;
            ST_WAIT:    if (mem_rsp_vld) state_d = mem_rsp_err ? ST_ABORT : ST_DELIVER;
            ST_DELIVER: state_d = cp_done ? ST_FINISH : ST_REQ;
            ST_FINISH:  state_d = ST_IDLE;
            ST_ABORT:   state_d = ST_IDLE;
            ST_UNDEF:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_op       = 1'b0;
        ld_start    = 1'b0;
        step        = 1'b0;
        capture     = 1'b0;
        cp_query    = 1'b0;
        mem_req_vld = 1'b0;
        cp_word_vld = 1'b0;
        wb_vld      = 1'b0;
        op_done     = 1'b0;
        undef_exc   = 1'b0;
        dabort      = 1'b0;
        busy        = (state_q != ST_IDLE);
        opt_vld     = busy && opt_q;
        unique case (state_q)
            ST_IDLE: begin
                ld_op = start;
            end
            ST_CHECK: begin
                cp_query = 1'b1;
                ld_start = cp_accept;
            end
            ST_REQ: begin
                mem_req_vld = 1'b1;
            end
            ST_WAIT: begin
                capture = mem_rsp_vld && !mem_rsp_err;
            end
            ST_DELIVER: begin
                cp_word_vld = 1'b1;
                step        = !cp_done;
            end
            ST_FINISH: begin
                op_done = 1'b1;
                wb_vld  = wb_q;
            end
            ST_ABORT: begin
                dabort = 1'b1;
            end
            ST_UNDEF: begin
                undef_exc = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cp_load_seq.sv
module cp_load_seq #(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned IMMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   base_in,
    input  logic [IMMW-1:0] imm8_in,
    input  logic            idx_in,
    input  logic            add_in,
    input  logic            wb_in,
    output logic            busy,
    output logic            cp_query,
    input  logic            cp_accept,
    output logic [IMMW-1:0] cp_opt,
    output logic            cp_opt_vld,
    output logic            mem_req_vld,
    input  logic            mem_req_rdy,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rsp_vld,
    input  logic [DW-1:0]   mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            cp_word_vld,
    output logic [DW-1:0]   cp_word,
    input  logic            cp_done,
    output logic            wb_vld,
    output logic [AW-1:0]   wb_addr,
    output logic            op_done,
    output logic            undef_exc,
    output logic            dabort
);
    logic ld_op;
    logic ld_start;
    logic step;
    logic capture;

    cpl_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .idx_i       (idx_in),
        .add_i       (add_in),
        .wb_i        (wb_in),
        .cp_accept   (cp_accept),
        .mem_req_rdy (mem_req_rdy),
        .mem_rsp_vld (mem_rsp_vld),
        .mem_rsp_err (mem_rsp_err),
        .cp_done     (cp_done),
        .ld_op       (ld_op),
        .ld_start    (ld_start),
        .step        (step),
        .capture     (capture),
        .busy        (busy),
        .cp_query    (cp_query),
        .opt_vld     (cp_opt_vld),
        .mem_req_vld (mem_req_vld),
        .cp_word_vld (cp_word_vld),
        .wb_vld      (wb_vld),
        .op_done     (op_done),
        .undef_exc   (undef_exc),
        .dabort      (dabort)
    );

    cpl_addr_unit #(.AW(AW), .IMMW(IMMW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_op    (ld_op),
        .base_i   (base_in),
        .imm_i    (imm8_in),
        .idx_i    (idx_in),
        .add_i    (add_in),
        .ld_start (ld_start),
        .step     (step),
        .off_addr (wb_addr),
        .cur_addr (mem_addr),
        .imm_q    (cp_opt)
    );

    cpl_word_buf #(.DW(DW)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .data_i  (mem_rsp_data),
        .data_q  (cp_word)
    );

endmodule

// File: rtl/cp_load_seq_chk.sv
module cp_load_seq_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          cp_query,
    input logic          cp_accept,
    input logic          cp_opt_vld,
    input logic          mem_req_vld,
    input logic          mem_req_rdy,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rsp_vld,
    input logic          mem_rsp_err,
    input logic          cp_word_vld,
    input logic          cp_done,
    input logic          wb_vld,
    input logic          op_done,
    input logic          undef_exc,
    input logic          dabort
);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_vld && !mem_req_rdy |=> mem_req_vld && $stable(mem_addr));

    assert_next_word_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cp_word_vld && !cp_done |=> mem_req_vld && (mem_addr == $past(mem_addr) + AW'(4)));

    assert_last_word_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cp_word_vld && cp_done |=> op_done);

    assert_wb_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> op_done);

    assert_reject_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cp_query && !cp_accept |=> undef_exc && !mem_req_vld);

    assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_vld && mem_rsp_err && !mem_req_vld && busy && !cp_query
        |=> dabort && !wb_vld && !cp_word_vld);

    assert_one_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_done, undef_exc, dabort}));

    assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && cp_query);

    assert_end_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_done || undef_exc || dabort |=> !busy);

    assert_outputs_need_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_vld && !cp_word_vld && !cp_opt_vld && !cp_query);

endmodule

bind cp_load_seq cp_load_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .cp_query    (cp_query),
    .cp_accept   (cp_accept),
    .cp_opt_vld  (cp_opt_vld),
    .mem_req_vld (mem_req_vld),
    .mem_req_rdy (mem_req_rdy),
    .mem_addr    (mem_addr),
    .mem_rsp_vld (mem_rsp_vld),
    .mem_rsp_err (mem_rsp_err),
    .cp_word_vld (cp_word_vld),
    .cp_done     (cp_done),
    .wb_vld      (wb_vld),
    .op_done     (op_done),
    .undef_exc   (undef_exc),
    .dabort      (dabort)
);

// File: tb/sim_cp_load_seq.sv
`timescale 1ns/1ps
module sim_cp_load_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_in = '0;
    logic [7:0]  imm8_in = '0;
    logic        idx_in = 1'b0, add_in = 1'b0, wb_in = 1'b0;
    logic        busy, cp_query, cp_opt_vld, mem_req_vld, cp_word_vld;
    logic        wb_vld, op_done, undef_exc, dabort;
    logic        cp_accept = 1'b0, mem_req_rdy = 1'b0, mem_rsp_vld = 1'b0;
    logic        mem_rsp_err = 1'b0, cp_done = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [7:0]  cp_opt;
    logic [31:0] mem_addr, cp_word, wb_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cp_load_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in), .imm8_in(imm8_in),
        .idx_in(idx_in), .add_in(add_in), .wb_in(wb_in), .busy(busy),
        .cp_query(cp_query), .cp_accept(cp_accept), .cp_opt(cp_opt), .cp_opt_vld(cp_opt_vld),
        .mem_req_vld(mem_req_vld), .mem_req_rdy(mem_req_rdy), .mem_addr(mem_addr),
        .mem_rsp_vld(mem_rsp_vld), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .cp_word_vld(cp_word_vld), .cp_word(cp_word), .cp_done(cp_done),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .op_done(op_done),
        .undef_exc(undef_exc), .dabort(dabort)
    );

    // results of the last operation
    int          r_term;      // 1 done, 2 undef, 3 abort, 0 none
    int          r_reqs;
    int          r_words;
    int          r_addr_bad;
    int          r_data_bad;
    int          r_busy_bad;
    int          r_opt_bad;
    logic        r_wb;
    logic [31:0] r_wb_addr;
    logic [31:0] r_first;
    int          r_busy_first;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'hA5A5_0F0F;
    endfunction

    function automatic logic [31:0] offs(input logic [31:0] b, input logic [7:0] i, input logic a);
        return a ? b + {22'd0, i, 2'b00} : b - {22'd0, i, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] b, input logic [7:0] i, input logic idx,
                          input logic add, input logic wb, input logic acc, input int nwords,
                          input int abort_at, input int stall, input bit poke);
        logic [31:0] exp_start;
        logic        pend = 1'b0;
        int          scnt = 0;
        logic        opt_mode;
        exp_start = idx ? offs(b, i, add) : b;
        opt_mode  = !idx && !wb && add;
        r_term = 0; r_reqs = 0; r_words = 0; r_addr_bad = 0; r_data_bad = 0;
        r_busy_bad = 0; r_opt_bad = 0; r_wb = 1'b0; r_wb_addr = '0; r_first = 32'hFFFF_FFFF;
        @(negedge clk);
        base_in = b; imm8_in = i; idx_in = idx; add_in = add; wb_in = wb;
        cp_accept = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_in = 32'hDEAD_0000; imm8_in = 8'h3C; idx_in = ~idx; add_in = ~add; wb_in = ~wb;
        r_busy_first = busy;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (!busy) r_busy_bad++;
            if (poke) start = (cyc == 3);
            if (busy && (cp_opt_vld !== opt_mode)) r_opt_bad++;
            if (opt_mode && cp_opt !== i) r_opt_bad++;
            mem_rsp_vld = 1'b0; mem_rsp_err = 1'b0; cp_done = 1'b0; mem_req_rdy = 1'b0;
            if (pend) begin
                mem_rsp_vld  = 1'b1;
                mem_rsp_err  = (r_reqs - 1 == abort_at);
                mem_rsp_data = mem_word(exp_start + 32'(4 * (r_reqs - 1)));
                pend = 1'b0;
            end
            if (mem_req_vld) begin
                if (scnt == 0) begin
                    if (r_reqs == 0) r_first = mem_addr;
                    if (mem_addr !== exp_start + 32'(4 * r_reqs)) r_addr_bad++;
                end
                if (scnt >= stall) begin
                    mem_req_rdy = 1'b1; pend = 1'b1; r_reqs++; scnt = 0;
                end else scnt++;
            end
            if (cp_word_vld) begin
                if (cp_word !== mem_word(exp_start + 32'(4 * r_words))) r_data_bad++;
                r_words++;
                cp_done = (r_words >= nwords);
            end
            if (op_done || undef_exc || dabort) begin
                r_term = op_done ? 1 : (undef_exc ? 2 : 3);
                r_wb = wb_vld; r_wb_addr = wb_addr;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0; mem_rsp_vld = 1'b0; mem_rsp_err = 1'b0; cp_done = 1'b0; mem_req_rdy = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R10 idle after end", 32'(busy), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !cp_query && !mem_req_vld && !cp_word_vld, "R1 reset outputs",
            {busy, cp_query, mem_req_vld, cp_word_vld}, 0);
        chk(!wb_vld && !op_done && !undef_exc && !dabort, "R1 reset pulses",
            {wb_vld, op_done, undef_exc, dabort}, 0);
    endtask

    task automatic t_offset_add();
        run_op(32'h0000_1000, 8'd5, 1, 1, 0, 1, 3, -1, 2, 0);
        chk(r_first == 32'h0000_1014, "R3 offset-mode first address", r_first, 32'h1014);
        chk(r_addr_bad == 0 && r_reqs == 3, "R4 address sequence / R9 hold", r_reqs, 3);
        chk(r_data_bad == 0 && r_words == 3, "R4 words forwarded", r_words, 3);
        chk(r_term == 1 && !r_wb, "R5 no writeback in offset mode", {r_term[30:0], r_wb}, 32'h2);
        chk(r_busy_first == 1 && r_busy_bad == 0, "R10 busy span", r_busy_bad, 0);
    endtask

    task automatic t_pre_sub();
        run_op(32'h0000_2000, 8'd255, 1, 0, 1, 1, 2, -1, 0, 0);
        chk(r_first == 32'h0000_1C04, "R2 subtract max immediate", r_first, 32'h1C04);
        chk(r_term == 1 && r_wb && r_wb_addr == 32'h0000_1C04, "R5 pre-indexed writeback",
            r_wb_addr, 32'h1C04);
        chk(r_addr_bad == 0 && r_words == 2, "R4 pre-indexed sequence", r_words, 2);
    endtask

    task automatic t_post();
        run_op(32'h0000_3000, 8'd4, 0, 1, 1, 1, 4, -1, 1, 0);
        chk(r_first == 32'h0000_3000, "R3 post-indexed starts at base", r_first, 32'h3000);
        chk(r_wb && r_wb_addr == 32'h0000_3010, "R5 writeback is offset not last address",
            r_wb_addr, 32'h3010);
        chk(r_addr_bad == 0 && r_data_bad == 0 && r_words == 4, "R4 post-indexed words", r_words, 4);
    endtask

    task automatic t_unindexed();
        run_op(32'h0000_4000, 8'hA7, 0, 1, 0, 1, 2, -1, 0, 0);
        chk(r_first == 32'h0000_4000, "R8 unindexed reads from base", r_first, 32'h4000);
        chk(r_opt_bad == 0, "R8 option value and valid", r_opt_bad, 0);
        chk(r_term == 1 && !r_wb, "R8 no writeback unindexed", 32'(r_wb), 0);
    endtask

    task automatic t_minus_zero();
        run_op(32'h0000_5000, 8'd0, 1, 0, 1, 1, 1, -1, 0, 0);
        chk(r_first == 32'h0000_5000 && r_wb_addr == 32'h0000_5000, "R11 minus zero",
            r_wb_addr, 32'h5000);
        run_op(32'h0000_5000, 8'd0, 1, 1, 1, 1, 1, -1, 0, 0);
        chk(r_first == 32'h0000_5000 && r_wb_addr == 32'h0000_5000, "R11 plus zero",
            r_wb_addr, 32'h5000);
        chk(r_words == 1 && r_reqs == 1, "R4 single word when done at first", r_words, 1);
    endtask

    task automatic t_reject();
        run_op(32'h0000_6000, 8'd1, 1, 1, 1, 0, 3, -1, 0, 0);
        chk(r_term == 2, "R6 undefined exception", r_term, 2);
        chk(r_reqs == 0 && r_words == 0 && !r_wb, "R6 no memory access", r_reqs, 0);
    endtask

    task automatic t_abort();
        run_op(32'h0000_7000, 8'd2, 1, 1, 1, 1, 5, 1, 0, 0);
        chk(r_term == 3, "R7 data abort raised", r_term, 3);
        chk(r_reqs == 2 && r_words == 1, "R7 loop stops at faulting read", r_reqs, 2);
        chk(!r_wb, "R7 writeback suppressed", 32'(r_wb), 0);
    endtask

    task automatic t_poke();
        run_op(32'h0000_8000, 8'd3, 1, 1, 1, 1, 3, -1, 1, 1);
        chk(r_first == 32'h0000_800C && r_addr_bad == 0, "R10 start while busy ignored",
            r_first, 32'h800C);
        chk(r_wb_addr == 32'h0000_800C && r_words == 3, "R10 writeback unaffected by start",
            r_wb_addr, 32'h800C);
    endtask

    task automatic t_wrap();
        run_op(32'h0000_0008, 8'd4, 1, 0, 1, 1, 2, -1, 0, 0);
        chk(r_first == 32'hFFFF_FFF8 && r_addr_bad == 0, "R2 subtract wraps modulo 2^32",
            r_first, 32'hFFFF_FFF8);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offset_add();
        t_pre_sub();
        t_post();
        t_unindexed();
        t_minus_zero();
        t_reject();
        t_abort();
        t_poke();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule